// File: doc/BRIEF.md
# Receive Byte Queue with Host-Visible Read Pointer

This block is the receive-side byte store of a CAN-style controller. A receive engine pushes message bytes into a 64-entry circular store one at a time. The host sees every stored byte through a word-aligned register window: entry k sits at byte address 0x80 + 4k. A separate register shows where the queue's read pointer currently stands. When the host has finished with a message, it hands back the consumed bytes with a release strobe that carries a byte count.

Two resets are handled differently. The system reset clears both pointers, the occupancy count and the overflow flag. The stored bytes are not cleared. The software reset, which accompanies entry into reset mode, keeps the read pointer and every stored byte. It moves the write pointer onto the read pointer, so the next received byte lands on the position the host would read first. The read pointer can be loaded by the host only while the controller is in reset mode.

An occupancy counter drives the empty, full and level outputs. A byte that arrives while the store is full is discarded and raises a sticky overflow flag.

Top module: `rxq_ptr_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, the read pointer, write pointer and occupancy are 0 and overflow is 0. `empty` is 1, `full` is 0 and `level` is 0.
- R2: A read at byte address 0x78 returns the read pointer in bits 5:0. Bits 31:6 return 0.
- R3: A host write to address 0x78 while `reset_mode` is 1 loads the read pointer from `host_wdata[5:0]` and moves the write pointer to the same value. Occupancy becomes 0 and bits 31:6 are ignored. When `reset_mode` is 0, such a write has no effect.
- R4: An accepted push stores `push_data` at the write pointer. The write pointer then advances by one modulo 64 and occupancy rises by one.
- R5: A release with count n advances the read pointer by min(n, occupancy) modulo 64 and lowers occupancy by the same amount.
- R6: `level` equals occupancy (0 to 64). `empty` is 1 exactly when occupancy is 0, and `full` is 1 exactly when occupancy is 64.
- R7: A push while `full` is 1 is dropped and sets `overflow`. `overflow` stays set until a system reset or a software reset.
- R8: A software reset keeps the read pointer and all stored bytes. It sets the write pointer equal to the read pointer and occupancy to 0, so the next push overwrites the byte at the read position.
- R9: A read at address 0x80 + 4k (k = 0..63, address bits 1:0 ignored) returns stored byte k in bits 7:0, with bits 31:8 as 0. A read at any other address except 0x78 returns 0.
- R10: A push and a release in the same cycle both take effect, and the push is judged against `full` as it stood before that cycle. A pointer load (R3) or a software reset in the same cycle overrides both. When a pointer load and a software reset coincide, the pointer load sets both pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset pulse |
| reset_mode | input | 1 | Controller is in reset mode |
| push_valid | input | 1 | Receive engine presents a byte |
| push_data | input | 8 | Received byte |
| rel_valid | input | 1 | Release strobe |
| rel_count | input | 7 | Number of bytes to release |
| host_addr | input | 9 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from address) |
| empty | output | 1 | Occupancy is 0 |
| full | output | 1 | Occupancy is 64 |
| overflow | output | 1 | Sticky dropped-push flag |
| level | output | 7 | Current occupancy |

## Verification
The functions that collide are pushes against releases, and both of those against a software reset or a pointer load. The bench drives them together on purpose. It pushes and releases in the same cycle while the store is full. It pushes in the same cycle as a software reset. It then runs a long stretch where every input toggles independently. A behavioural model applies the priority order of R10 and judges each cycle. It compares the flags, the level and the read data at whatever address is presented, so a wrong winner shows up either in the occupancy or in the byte read back at the read pointer.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      HSEL_NONE = 2'd0,
      HSEL_PTR  = 2'd1,
      HSEL_WIN  = 2'd2
   } hsel_e;

   function automatic int unsigned win_end(input int unsigned base, input int unsigned depth);
      return base + 4 * depth;
   endfunction

endpackage

// File: rtl/rxq_decode.sv
module rxq_decode
   import rxq_pkg::*;
#(
   parameter int unsigned HADDR_W  = 9,
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned WIN_BASE = 32'h80,
   parameter int unsigned PTR_OFS  = 32'h78,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic [HADDR_W-1:0] addr,
   output hsel_e              sel,
   output logic [PTR_W-1:0]   index
);
   localparam logic [HADDR_W:0]   WIN_LO = (HADDR_W+1)'(WIN_BASE);
   localparam logic [HADDR_W:0]   WIN_HI = (HADDR_W+1)'(win_end(WIN_BASE, DEPTH));
   localparam logic [HADDR_W-1:0] PTR_A  = HADDR_W'(PTR_OFS);

   logic [HADDR_W-1:0] offset;
   logic               in_win;

   assign offset = addr - WIN_LO[HADDR_W-1:0];
   assign in_win = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
   assign index  = offset[PTR_W+1:2];

   always_comb begin
      if (addr == PTR_A)  sel = HSEL_PTR;
      else if (in_win)    sel = HSEL_WIN;
      else                sel = HSEL_NONE;
   end

   logic unused_off_lo;
   assign unused_off_lo = ^{offset[1:0], offset[HADDR_W-1:PTR_W+2]};

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned DATA_W = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      always_ff @(posedge clk) begin
         if (we && (waddr == PTR_W'(gi))) cell_q[gi] <= wdata;
      end
   end

   assign rdata = cell_q[raddr];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int unsigned DEPTH = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             reset_mode,
   input  logic             push_valid,
   input  logic             rel_valid,
   input  logic [CNT_W-1:0] rel_count,
   input  logic             ptr_wr_req,
   input  logic [PTR_W-1:0] ptr_wval,
   output logic             we,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic [CNT_W-1:0] count,
   output logic             overflow
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] count_q;
   logic             ovf_q;
   logic             is_full, ptr_load, push_ok;
   logic [CNT_W-1:0] rel_n;

   assign is_full  = (count_q == FULL_CNT);
   assign ptr_load = ptr_wr_req && reset_mode;
   assign push_ok  = push_valid && !is_full;
   assign we       = push_ok && !ptr_load && !soft_rst;

   always_comb begin
      rel_n = '0;
      if (rel_valid) rel_n = (rel_count > count_q) ? count_q : rel_count;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         rptr_q  <= '0;
         count_q <= '0;
      end else if (ptr_load) begin
         wptr_q  <= ptr_wval;
         rptr_q  <= ptr_wval;
         count_q <= '0;
      end else if (soft_rst) begin
         wptr_q  <= rptr_q;
         count_q <= '0;
      end else begin
         if (push_ok) wptr_q <= wptr_q + 1'b1;
         rptr_q  <= rptr_q + rel_n[PTR_W-1:0];
         count_q <= count_q + CNT_W'(push_ok) - rel_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ovf_q <= 1'b0;
      else if (soft_rst)                            ovf_q <= 1'b0;
      else if (!ptr_load && push_valid && is_full)  ovf_q <= 1'b1;
   end

   assign wptr     = wptr_q;
   assign rptr     = rptr_q;
   assign count    = count_q;
   assign overflow = ovf_q;

   // R3: pointer write outside reset mode leaves the read pointer alone
   a_r3_ptr_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr_req && !reset_mode && !rel_valid && !soft_rst) |=> $stable(rptr_q));

   // R4: an accepted push without release raises occupancy by one
   a_r4_push_count: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !rel_valid) |=> (count_q == $past(count_q) + 1'b1));

   // R4: an accepted push advances the write pointer
   a_r4_push_wptr: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (wptr_q == $past(wptr_q) + 1'b1));

   // R6: occupancy never exceeds the depth
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);

   // R7: push while full sets overflow
   a_r7_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && is_full && !soft_rst && !ptr_load) |=> ovf_q);

   // R7: overflow is sticky until a software reset
   a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !soft_rst) |=> ovf_q);

   // R8: software reset snaps the write pointer onto an unchanged read pointer
   a_r8_soft_snap: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !ptr_load) |=> ((wptr_q == $past(rptr_q)) && $stable(rptr_q) && (count_q == '0)));

endmodule

// File: rtl/rxq_ptr_fifo.sv
module rxq_ptr_fifo
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH    = 64,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BUS_W    = 32,
   parameter int unsigned HADDR_W  = 9,
   parameter int unsigned WIN_BASE = 32'h80,
   parameter int unsigned PTR_OFS  = 32'h78,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               reset_mode,
   input  logic               push_valid,
   input  logic [DATA_W-1:0]  push_data,
   input  logic               rel_valid,
   input  logic [CNT_W-1:0]   rel_count,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic               host_wr,
   input  logic [BUS_W-1:0]   host_wdata,
   output logic [BUS_W-1:0]   host_rdata,
   output logic               empty,
   output logic               full,
   output logic               overflow,
   output logic [CNT_W-1:0]   level
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("rxq_ptr_fifo: DEPTH must be a power of two >= 2");
   end
   if ((WIN_BASE % 4) != 0) begin : g_bad_base
      $error("rxq_ptr_fifo: WIN_BASE must be word aligned");
   end
   if (win_end(WIN_BASE, DEPTH) > (1 << HADDR_W)) begin : g_bad_span
      $error("rxq_ptr_fifo: window does not fit the host address width");
   end
   if ((PTR_OFS >= WIN_BASE) && (PTR_OFS < win_end(WIN_BASE, DEPTH))) begin : g_bad_ptr
      $error("rxq_ptr_fifo: pointer register overlaps the window");
   end
   if ((BUS_W < DATA_W) || (BUS_W <= PTR_W)) begin : g_bad_bus
      $error("rxq_ptr_fifo: BUS_W too narrow");
   end

   hsel_e             sel;
   logic [PTR_W-1:0]  win_idx;
   logic              we;
   logic [PTR_W-1:0]  wptr, rptr;
   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] rd_byte;
   logic              ptr_wr_req;

   rxq_decode #(
      .HADDR_W (HADDR_W),
      .DEPTH   (DEPTH),
      .WIN_BASE(WIN_BASE),
      .PTR_OFS (PTR_OFS)
   ) u_dec (
      .addr (host_addr),
      .sel  (sel),
      .index(win_idx)
   );

   assign ptr_wr_req = host_wr && (sel == HSEL_PTR);

   rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .reset_mode(reset_mode),
      .push_valid(push_valid),
      .rel_valid (rel_valid),
      .rel_count (rel_count),
      .ptr_wr_req(ptr_wr_req),
      .ptr_wval  (host_wdata[PTR_W-1:0]),
      .we        (we),
      .wptr      (wptr),
      .rptr      (rptr),
      .count     (count),
      .overflow  (overflow)
   );

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk  (clk),
      .we   (we),
      .waddr(wptr),
      .wdata(push_data),
      .raddr(win_idx),
      .rdata(rd_byte)
   );

   always_comb begin
      case (sel)
         HSEL_PTR: host_rdata = BUS_W'(rptr);
         HSEL_WIN: host_rdata = BUS_W'(rd_byte);
         default:  host_rdata = '0;
      endcase
   end

   assign level = count;
   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^host_wdata[BUS_W-1:PTR_W];

   // R6: empty and full never coincide
   a_r6_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));

   // R2: pointer register upper bits read zero
   a_r2_ptr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == HSEL_PTR) |-> (host_rdata[BUS_W-1:PTR_W] == '0));

endmodule

// File: tb/tb_rxq_ptr_fifo.sv
module tb_rxq_ptr_fifo;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        soft_rst, reset_mode, push_valid, rel_valid, host_wr;
   logic [7:0]  push_data;
   logic [6:0]  rel_count;
   logic [8:0]  host_addr;
   logic [31:0] host_wdata;
   logic [31:0] host_rdata;
   logic        empty, full, overflow;
   logic [6:0]  level;

   always #10 clk = ~clk;

   rxq_ptr_fifo dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reset_mode(reset_mode),
      .push_valid(push_valid), .push_data(push_data),
      .rel_valid(rel_valid), .rel_count(rel_count),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .empty(empty), .full(full),
      .overflow(overflow), .level(level)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int m_r, m_w, m_c;
   bit m_o;
   byte unsigned m_mem [64];
   bit  m_ok [64];

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_r = 0; m_w = 0; m_c = 0; m_o = 0;
   endtask

   task automatic model_step();
      bit ptrw, was_full, push_ok;
      int reln;
      if (!rst_n) begin
         model_reset();
         return;
      end
      ptrw     = host_wr && reset_mode && (host_addr == 9'h078);
      was_full = (m_c == 64);
      push_ok  = push_valid && !was_full;
      reln     = rel_valid ? ((int'(rel_count) > m_c) ? m_c : int'(rel_count)) : 0;
      if (ptrw) begin
         m_r = int'(host_wdata[5:0]); m_w = m_r; m_c = 0;
      end else if (soft_rst) begin
         m_w = m_r; m_c = 0;
      end else begin
         if (push_ok) begin
            m_mem[m_w] = push_data; m_ok[m_w] = 1'b1; m_w = (m_w + 1) % 64;
         end
         m_r = (m_r + reln) % 64;
         m_c = m_c + int'(push_ok) - reln;
      end
      if (soft_rst) m_o = 1'b0;
      else if (!ptrw && push_valid && was_full) m_o = 1'b1;
   endtask

   task automatic compare();
      int a, k;
      chk("R6", "level", level, m_c);
      chk("R6", "empty", empty, m_c == 0);
      chk("R6", "full",  full,  m_c == 64);
      chk("R7", "overflow", overflow, m_o);
      a = int'(host_addr);
      if (a == 'h78) chk("R2", "ptr reg", host_rdata, m_r);
      else if (a >= 'h80 && a < 'h180) begin
         k = (a - 'h80) / 4;
         if (m_ok[k]) chk("R9", "window", host_rdata, m_mem[k]);
      end else chk("R9", "unmapped read", host_rdata, 0);
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      soft_rst = 0; push_valid = 0; rel_valid = 0; host_wr = 0;
      push_data = 0; rel_count = 0; host_wdata = 0;
   endtask

   task automatic push(input byte unsigned d);
      idle(); push_valid = 1; push_data = d; tick();
   endtask

   task automatic release_n(input int n);
      idle(); rel_valid = 1; rel_count = 7'(n); tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      foreach (m_ok[i]) m_ok[i] = 1'b0;
      model_reset();
      rst_n = 0; reset_mode = 0; host_addr = 9'h078; idle();
      // R1: reset state
      tick(); tick();
      rst_n = 1; tick();
      chk("R1", "empty after reset", empty, 1);
      chk("R2", "ptr after reset", host_rdata, 0);

      // R4: pushes land at consecutive locations, read back through window (R9)
      for (int i = 0; i < 10; i++) push(byte'(8'hA0 + i));
      for (int i = 0; i < 10; i++) begin
         idle(); host_addr = 9'(9'h080 + 4 * i + (i % 4)); tick();
      end
      idle(); host_addr = 9'h07C; tick();   // R9: unmapped address reads 0
      idle(); host_addr = 9'h180; tick();

      // R5: release advances the read pointer
      host_addr = 9'h078;
      release_n(3);
      chk("R5", "rptr after release 3", host_rdata, 3);

      // R3: pointer write outside reset mode is ignored
      idle(); host_wr = 1; host_wdata = 32'h0000_0021; tick();
      chk("R3", "ptr write ignored", host_rdata, 3);

      // R6 R7: fill to full, then push more
      while (level != 7'd64) push(byte'($urandom));
      chk("R6", "full flag", full, 1);
      push(8'h55);
      chk("R7", "overflow set", overflow, 1);
      // R10: push and release together while full: push dropped, release applies
      idle(); push_valid = 1; push_data = 8'h66; rel_valid = 1; rel_count = 7'd2; tick();
      chk("R10", "level after full push+release", level, 62);
      // R10: push and release together when not full
      idle(); push_valid = 1; push_data = 8'h77; rel_valid = 1; rel_count = 7'd1; tick();
      chk("R10", "level after push+release", level, 62);
      // R5: oversized release is clamped, pointer wraps
      release_n(100);
      chk("R5", "empty after clamp", empty, 1);
      chk("R7", "overflow still set", overflow, 1);

      // R8: software reset with simultaneous push; push overridden
      push(8'h11); push(8'h22); push(8'h33);
      idle(); soft_rst = 1; reset_mode = 1; push_valid = 1; push_data = 8'hEE; tick();
      chk("R8", "level after soft reset", level, 0);
      chk("R7", "overflow cleared by soft reset", overflow, 0);
      idle(); push(8'hC3);
      idle(); host_addr = 9'(9'h080 + 4 * m_r); tick();
      chk("R8", "overwrite at read pos", host_rdata, 8'hC3);
      idle(); host_addr = 9'(9'h080 + 4 * ((m_r + 1) % 64)); tick();

      // R3: pointer write in reset mode; upper bits ignored
      idle(); host_addr = 9'h078; host_wr = 1; host_wdata = 32'hFFFF_FFC5; tick();
      chk("R3", "ptr loaded", host_rdata, 5);
      chk("R3", "level zero after load", level, 0);
      // R10: pointer write and soft reset together
      idle(); host_wr = 1; host_wdata = 32'h0000_003E; soft_rst = 1; tick();
      chk("R10", "ptr load wins", host_rdata, 62);
      reset_mode = 0;
      push(8'h01); push(8'h02); push(8'h03);   // R4: wraps past 63
      idle(); host_addr = 9'h080; tick();

      // mixed traffic
      for (int c = 0; c < 4000; c++) begin
         int sel;
         idle();
         push_valid = ($urandom_range(0, 1) == 1);
         push_data  = 8'($urandom);
         rel_valid  = ($urandom_range(0, 3) == 0);
         rel_count  = 7'($urandom_range(0, 12));
         soft_rst   = ($urandom_range(0, 79) == 0);
         if ($urandom_range(0, 31) == 0) reset_mode = ~reset_mode;
         sel = $urandom_range(0, 7);
         host_addr  = (sel == 0) ? 9'h078 : 9'($urandom_range(0, 511));
         host_wr    = ($urandom_range(0, 15) == 0) && (sel == 0);
         host_wdata = $urandom;
         if (c == 2000) rst_n = 0;      // R1: system reset mid-run
         if (c == 2002) rst_n = 1;
         tick();
      end

      idle(); rst_n = 0; tick();
      chk("R1", "overflow cleared by system reset", overflow, 0);
      rst_n = 1; tick();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule